// File: doc/BRIEF.md
# Pulsed Beam Missing-Pulse Detector

This block paces two infrared emitters and judges, for each beam, whether it is clear or broken. A free-running sequencer divides time into a repeating period of four equal slots. Emitter 0 is driven during slot 0 and emitter 1 during slot 2, so the two emitters are never lit together and receiver crosstalk cannot be mistaken for a pulse.

Each receiver comparator output is asynchronous. It passes through a two-flop synchronizer and is judged once per period, in the last cycle of its own channel's emitter window. A hit raises a saturating 4-bit integrator by one. A miss lowers it by one. The integrator MSB decides the beam state, so a few lost or stray pulses do not flip the filtered output. Two indicator drives per channel report the latest judgement: "good" after a hit and "bad" after a miss. With a marginal signal the two drives alternate, and both appear lit.

With the default parameter and a 100 MHz clock, a slot is 25 µs and the period is 100 µs.

Top module: `beam_pulse_monitor`

## Requirements
- R1: After reset, emit_o[0] is high for the first SLOT_CYCLES cycles of every period of 4*SLOT_CYCLES cycles (slot 0). emit_o[1] is high for slot 2, which covers cycles 2*SLOT_CYCLES to 3*SLOT_CYCLES-1 of the period. Both are low otherwise.
- R2: emit_o[0] and emit_o[1] are never high in the same cycle.
- R3: Channel c is judged once per period, at the clock edge that ends its own emitter slot. The value judged is rx_i[c] as registered two edges earlier. rx_i[c] levels outside that slot have no effect.
- R4: A judgement with rx high (a hit) raises the channel's 4-bit count by one, holding at 15.
- R5: A judgement with rx low (a miss) lowers the count by one, holding at 0.
- R6: broken_o[c] is 1 while the count is 7 or below and 0 while it is 8 or above. The count resets to 0, so both beams read broken after reset.
- R7: After each judgement, good_o[c] equals the hit result and bad_o[c] equals its complement, held until the next judgement. Reset gives good_o=0 and bad_o=1.
- R8: The two channels are independent. Stimulus on one receiver never changes the other channel's count or indicators.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 2 | Asynchronous comparator outputs, one per beam |
| emit_o | output | 2 | Emitter drive pulses |
| broken_o | output | 2 | Filtered beam-broken flag per channel |
| good_o | output | 2 | Beam-good indicator drive per channel |
| bad_o | output | 2 | Beam-bad indicator drive per channel |

## Verification
The assertions assume that rx_i only matters through its synchronized copy, and that SLOT_CYCLES is at least 3. With SLOT_CYCLES of 3 or more, a receiver level set early in a window reaches the synchronizer output before the sampling edge. The stimulus changes each receiver only on falling clock edges. Each receiver either follows its own emitter, stays low, or is the inverse of its emitter, which gives hits, misses and stray out-of-window pulses. Receiver modes change only in slot 3, where neither channel is being judged, so every judgement sees one stable mode for the whole period.

// File: rtl/beam_pkg.sv
package beam_pkg;
  localparam int NUM_CH    = 2;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_IW   = $clog2(NUM_SLOTS);

  // slot in which channel ch drives its emitter (opposite phase)
  function automatic logic [SLOT_IW-1:0] ch_slot(input int ch);
    return SLOT_IW'(ch * (NUM_SLOTS / NUM_CH));
  endfunction
endpackage

// File: rtl/beam_pulse_seq.sv
module beam_pulse_seq
  import beam_pkg::*;
#(
  parameter int SLOT_CYCLES = 2500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [NUM_CH-1:0] emit_o,
  output logic [NUM_CH-1:0] smp_o
);
  localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

  logic [CW-1:0]      slot_cnt_q, slot_cnt_d;
  logic [SLOT_IW-1:0] slot_idx_q, slot_idx_d;
  logic               slot_end;
  logic [NUM_CH-1:0]  emit_d, emit_q;

  assign slot_end   = (slot_cnt_q == LAST);
  assign slot_cnt_d = slot_end ? '0 : slot_cnt_q + 1'b1;
  assign slot_idx_d = slot_end ? slot_idx_q + 1'b1 : slot_idx_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign emit_d[c] = (slot_idx_d == ch_slot(c));
    assign smp_o[c]  = slot_end && (slot_idx_q == ch_slot(c));

    p_smp_in_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_o[c] |-> emit_o[c]);
    p_emit_ends_after_smp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_o[c] |=> !emit_o[c]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_cnt_q <= '0;
      slot_idx_q <= '0;
      for (int c = 0; c < NUM_CH; c++) emit_q[c] <= (ch_slot(c) == '0);
    end else begin
      slot_cnt_q <= slot_cnt_d;
      slot_idx_q <= slot_idx_d;
      emit_q     <= emit_d;
    end
  end

  assign emit_o = emit_q;

  initial begin
    assert (SLOT_CYCLES >= 3) else $error("SLOT_CYCLES must cover synchronizer latency");
  end

  p_no_overlap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(emit_o) <= 1);
  p_emit_steady_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_cnt_q != '0) |-> $stable(emit_o));
endmodule

// File: rtl/beam_sync.sv
module beam_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end
endmodule

// File: rtl/beam_integrator.sv
module beam_integrator #(
  parameter int CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  input  logic hit_i,
  output logic broken_o,
  output logic good_o,
  output logic bad_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             good_q, bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
      bad_q  <= 1'b1;
    end else if (smp_i) begin
      good_q <= hit_i;
      bad_q  <= !hit_i;
      if (hit_i) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end else begin
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign broken_o = !cnt_q[CNT_W-1];
  assign good_o   = good_q;
  assign bad_o    = bad_q;

  p_hold_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && hit_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  p_step_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && hit_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_hold_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && !hit_i && cnt_q == '0) |=> cnt_q == '0);
  p_step_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i && !hit_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_i |=> $stable(cnt_q) && $stable(good_o));
  p_break_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(broken_o) |-> $past(smp_i) && !$past(hit_i));
  p_ind_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_o != bad_o);
endmodule

// File: rtl/beam_pulse_monitor.sv
module beam_pulse_monitor
  import beam_pkg::*;
#(
  parameter int SLOT_CYCLES = 2500,
  parameter int CNT_W       = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rx_i,
  output logic [1:0] emit_o,
  output logic [1:0] broken_o,
  output logic [1:0] good_o,
  output logic [1:0] bad_o
);
  logic [NUM_CH-1:0] smp, rx_s;

  beam_pulse_seq #(.SLOT_CYCLES(SLOT_CYCLES)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .emit_o (emit_o),
    .smp_o  (smp)
  );

  beam_sync #(.W(NUM_CH)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (rx_s)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    beam_integrator #(.CNT_W(CNT_W)) i_integ (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .smp_i    (smp[c]),
      .hit_i    (rx_s[c]),
      .broken_o (broken_o[c]),
      .good_o   (good_o[c]),
      .bad_o    (bad_o[c])
    );
  end

  // R8: a channel's indicators change only at that channel's own judgement
  p_chan_indep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp[0] |=> $stable(good_o[0]) && $stable(broken_o[0]));
endmodule

// File: tb/test_beam_pulse_monitor.sv
module test_beam_pulse_monitor;
  localparam int S   = 4;
  localparam int PER = 4 * S;

  typedef struct {
    int    per;
    int    ch;
    string tag;
    logic  broken;
    logic  good;
    logic  bad;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rx = 2'b00;
  logic [1:0] emit, broken, good, bad;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  int   mode [2] = '{0, 0};   // 0 blocked, 1 clear, 2 stray (inverse of emitter)
  int   mcnt [2] = '{0, 0};
  exp_t q[$];

  beam_pulse_monitor #(.SLOT_CYCLES(S)) i_beam_pulse_monitor (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx),
    .emit_o(emit), .broken_o(broken), .good_o(good), .bad_o(bad)
  );

  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // receiver stimulus
  always @(negedge clk) begin
    for (int c = 0; c < 2; c++)
      rx[c] <= (mode[c] == 1) ? emit[c] : (mode[c] == 2) ? !emit[c] : 1'b0;
  end

  // driver: set modes in slot 3 for the next period, push expectations
  task automatic apply_period(int ma, int mb, string tag);
    exp_t e;
    int   m [2];
    m[0] = ma;
    m[1] = mb;
    do @(negedge clk); while (cyc % PER != 12);
    for (int c = 0; c < 2; c++) begin
      mode[c] = m[c];
      if (m[c] == 1) begin
        if (mcnt[c] < 15) mcnt[c]++;
      end else begin
        if (mcnt[c] > 0) mcnt[c]--;
      end
      e.per    = cyc / PER + 1;
      e.ch     = c;
      e.tag    = tag;
      e.broken = (mcnt[c] < 8);
      e.good   = (m[c] == 1);
      e.bad    = (m[c] != 1);
      q.push_back(e);
    end
    @(negedge clk);
  endtask

  // monitor: emitter timing every cycle, channel results one cycle after each judgement
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ph;
      ph = cyc % PER;
      chk("R1", int'(emit[0]), int'(ph < S), "emit0");
      chk("R1", int'(emit[1]), int'(ph >= 2*S && ph < 3*S), "emit1");
      chk("R2", int'(emit[0] & emit[1]), 0, "overlap");
      if (ph == S + 1 || ph == 3*S + 1) begin
        int ch;
        ch = (ph == S + 1) ? 0 : 1;
        if (q.size() > 0 && q[0].per == cyc / PER && q[0].ch == ch) begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, int'(broken[ch]), int'(e.broken), $sformatf("broken%0d", ch));
          chk("R7",  int'(good[ch]),   int'(e.good),   $sformatf("good%0d", ch));
          chk("R7",  int'(bad[ch]),    int'(e.bad),    $sformatf("bad%0d", ch));
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R6", int'(broken), 3, "reset broken");
    chk("R7", int'(good), 0, "reset good");
    chk("R7", int'(bad), 3, "reset bad");
    chk("R1", int'(emit), 1, "reset emit");
    rst_n = 1'b1;
    // R4/R6: both clear, count rises through 8 and pins at 15
    repeat (20) apply_period(1, 1, "R4");
    // R8: channel 0 blocked, channel 1 stays clear
    repeat (8)  apply_period(0, 1, "R8");
    // R5: channel 0 floors at 0, channel 1 blocked too
    repeat (12) apply_period(0, 0, "R5");
    repeat (8)  apply_period(1, 0, "R5");
    // R3: stray light outside own window counts as miss
    repeat (10) apply_period(2, 2, "R3");
    repeat (9)  apply_period(1, 2, "R3");
    // R7: marginal signal alternates indicators
    for (int i = 0; i < 12; i++) apply_period(i % 2, (i + 1) % 2, "R7");
    // R6: hover around threshold
    repeat (6)  apply_period(1, 1, "R6");
    repeat (3)  apply_period(0, 1, "R6");
    repeat (2)  apply_period(1, 0, "R6");
    repeat (2 * PER) @(negedge clk);
    chk("R3", q.size(), 0, "unconsumed expectations");
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule